// File: doc/BRIEF.md
# Byte-Parallel Serial Line Bridge

This block lets a host on an 8-bit I/O bus talk to a peripheral that has a single bidirectional serial data line. The host reads or writes one whole byte in a single bus cycle, and the bridge does the bit-by-bit work on the serial side without further help from the host. The shift clock for the peripheral is the bus clock, gated by the bridge's state machine and inverted.

A write is taken into the shift register at once. The bus cycle finishes with no wait states, and the byte then shifts out while the bus is free for other work. A read holds the bus ready output low until every bit has shifted in, and then puts the assembled byte on the data bus. A read that arrives while a write is still shifting out waits until the outgoing byte is complete, so neither transfer is corrupted.

The state machine has four states. IDLE is encoded 000 and LOAD is encoded 011. A write runs IDLE, LOAD, MOVE, IDLE. A read runs IDLE, MOVE, DONE, IDLE.

Top module: `ser_byte_bridge`

## Requirements
- R1: While `bus_rst` is high and after it falls, `per_sel` is 0, `bus_rdy` is 1, `ser_oe` is 0, `bus_doe` is 0 and `sclk` is 0, even when reset arrives in the middle of a transfer.
- R2: A write request (`wr_n` low with `sel_n` low) never pulls `bus_rdy` low.
- R3: A written byte leaves on `ser_do` most-significant bit first. Each bit is stable at the rising edge of `sclk` that the peripheral uses to sample it.
- R4: `ser_oe` is 1 only while a write is loading or shifting. It is 0 during reads and in idle, and it is never 1 at the same time as `bus_doe`.
- R5: A read request pulls `bus_rdy` low at once. Sampled once per clock starting in the cycle of the request, `bus_rdy` stays low for exactly DATA_W+1 samples, after which all DATA_W bits have been shifted in.
- R6: A read assembles the bits from `ser_di` most-significant first. The byte appears on `bus_dout` with `bus_doe` at 1 only after the shift is complete and only while `rd_n` and `sel_n` are both low. `bus_doe` falls as soon as the strobe is released.
- R7: A read requested while a write is still shifting keeps `bus_rdy` low until the write has finished and the read has completed (2*DATA_W+1 samples when the read arrives one cycle after the write is loaded), and both bytes arrive intact.
- R8: `per_sel` is 1 from the first cycle after a transfer is accepted until that transfer ends, and 0 in idle.
- R9: Each transfer produces exactly DATA_W `sclk` pulses. `sclk` is high only during the low phase of the clock while shifting.
- R10: A new write strobe that starts while a transfer is in progress is ignored. Only the first byte is shifted out, and no further `sclk` pulses follow.
- R11: Read or write strobes with `sel_n` high start no transfer. There are no `sclk` pulses, and `per_sel` and `bus_rdy` stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the source of the shift clock |
| bus_rst | input | 1 | Synchronous active-high bus reset |
| rd_n | input | 1 | Active-low I/O read strobe |
| wr_n | input | 1 | Active-low I/O write strobe |
| sel_n | input | 1 | Active-low address-decode enable |
| bus_din | input | DATA_W | Byte written by the host |
| bus_dout | output | DATA_W | Byte returned to the host |
| bus_doe | output | 1 | Enable for driving `bus_dout` onto the bus |
| bus_rdy | output | 1 | Bus ready; low stretches the current cycle |
| per_sel | output | 1 | Active-high peripheral chip select |
| sclk | output | 1 | Gated, inverted shift clock to the peripheral |
| ser_do | output | 1 | Serial data driven toward the peripheral |
| ser_oe | output | 1 | Tristate enable of the serial line driver |
| ser_di | input | 1 | Serial data received from the shared line |

## Verification
The checker watches the following on every cycle:
- that the serial driver and the bus data driver are never on together;
- that the parallel output appears only under an active read strobe and enable;
- that a pending read in idle already stalls the bus;
- that a write never stalls it;
- that no shift phase runs longer than DATA_W cycles.

Only the bench's scenarios can show the rest: that the bits leave and arrive in the right order for every byte value, that the stall lasts exactly the expected number of cycles, that a write-then-read pair completes intact, and that a late write strobe is really dropped.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'b000,
      ST_MOVE = 3'b001,
      ST_DONE = 3'b010,
      ST_LOAD = 3'b011
   } ssb_state_e;
endpackage

// File: rtl/ssb_bitcnt.sv
module ssb_bitcnt #(
   parameter int DATA_W = 8,
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic clk,
   input  logic clr,
   input  logic inc,
   output logic last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (clr)
         cnt_q <= '0;
      else if (inc)
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign last = (cnt_q == CNT_W'(DATA_W - 1));
endmodule

// File: rtl/ssb_shreg.sv
module ssb_shreg #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] pdata,
   input  logic              sin,
   output logic [DATA_W-1:0] q,
   output logic              sout
);
   logic [DATA_W-1:0] nxt_shift;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nxt_shift = {q[DATA_W-2:0], sin};
         assign sout      = q[DATA_W-1];
      end else begin : g_lsb
         assign nxt_shift = {sin, q[DATA_W-1:1]};
         assign sout      = q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= pdata;
      else if (shift)
         q <= nxt_shift;
   end
endmodule

// File: rtl/ssb_fsm.sv
module ssb_fsm
   import ssb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_go,
   input  logic       rd_req,
   input  logic       last,
   output ssb_state_e st,
   output logic       dir_wr,
   output logic       load,
   output logic       shift,
   output logic       cnt_clr
);
   ssb_state_e st_nxt;
   logic       dir_nxt;

   always_comb begin
      st_nxt  = st;
      dir_nxt = dir_wr;
      load    = 1'b0;
      shift   = 1'b0;
      cnt_clr = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (wr_go) begin
               load    = 1'b1;
               dir_nxt = 1'b1;
               st_nxt  = ST_LOAD;
            end else if (rd_req) begin
               cnt_clr = 1'b1;
               dir_nxt = 1'b0;
               st_nxt  = ST_MOVE;
            end
         end
         ST_LOAD: begin
            cnt_clr = 1'b1;
            st_nxt  = ST_MOVE;
         end
         ST_MOVE: begin
            shift = 1'b1;
            if (last)
               st_nxt = dir_wr ? ST_IDLE : ST_DONE;
         end
         ST_DONE: begin
            if (!rd_req)
               st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_IDLE;
         dir_wr <= 1'b0;
      end else begin
         st     <= st_nxt;
         dir_wr <= dir_nxt;
      end
   end
endmodule

// File: rtl/ser_byte_bridge.sv
module ser_byte_bridge
   import ssb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              bus_rst,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              sel_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic              bus_rdy,
   output logic              per_sel,
   output logic              sclk,
   output logic              ser_do,
   output logic              ser_oe,
   input  logic              ser_di
);
   initial begin
      if (DATA_W < 2)
         $error("ser_byte_bridge: DATA_W must be at least 2");
   end

   ssb_state_e st_q;
   logic rd_req, wr_req, wr_req_q, wr_go;
   logic dir_wr, load, shift, cnt_clr, last;

   assign rd_req = ~rd_n & ~sel_n;
   assign wr_req = ~wr_n & ~sel_n;

   always_ff @(posedge clk) begin
      if (bus_rst)
         wr_req_q <= 1'b0;
      else
         wr_req_q <= wr_req;
   end

   assign wr_go = wr_req & ~wr_req_q;

   ssb_fsm fsm_i (
      .clk     (clk),
      .rst     (bus_rst),
      .wr_go   (wr_go),
      .rd_req  (rd_req),
      .last    (last),
      .st      (st_q),
      .dir_wr  (dir_wr),
      .load    (load),
      .shift   (shift),
      .cnt_clr (cnt_clr)
   );

   ssb_bitcnt #(.DATA_W(DATA_W)) cnt_i (
      .clk  (clk),
      .clr  (cnt_clr | bus_rst),
      .inc  (shift),
      .last (last)
   );

   ssb_shreg #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) sr_i (
      .clk   (clk),
      .rst   (bus_rst),
      .load  (load),
      .shift (shift),
      .pdata (bus_din),
      .sin   (ser_di),
      .q     (bus_dout),
      .sout  (ser_do)
   );

   assign per_sel = (st_q != ST_IDLE);
   assign sclk    = (st_q == ST_MOVE) & ~clk;
   assign ser_oe  = dir_wr & ((st_q == ST_LOAD) | (st_q == ST_MOVE));
   assign bus_doe = (st_q == ST_DONE) & rd_req;
   assign bus_rdy = bus_rst | ~(rd_req & (st_q != ST_DONE));
endmodule

// File: rtl/ser_byte_bridge_chk.sv
module ser_byte_bridge_chk #(
   parameter int DATA_W = 8
) (
   input logic       clk,
   input logic       bus_rst,
   input logic       rd_n,
   input logic       wr_n,
   input logic       sel_n,
   input logic       bus_doe,
   input logic       bus_rdy,
   input logic       per_sel,
   input logic       ser_oe,
   input logic [2:0] st
);
   localparam logic [2:0] MOVE_CODE = 3'b001;

   int unsigned mv_run;

   always_ff @(posedge clk) begin
      if (bus_rst)
         mv_run <= 0;
      else if (st == MOVE_CODE)
         mv_run <= mv_run + 1;
      else
         mv_run <= 0;
   end

   p_no_contention_r4: assert property (@(posedge clk) disable iff (bus_rst)
      $onehot0({bus_doe, ser_oe}));

   p_oe_needs_sel_r4: assert property (@(posedge clk) disable iff (bus_rst)
      ser_oe |-> per_sel);

   p_doe_gated_r6: assert property (@(posedge clk) disable iff (bus_rst)
      bus_doe |-> (!rd_n && !sel_n && bus_rdy));

   p_idle_read_stall_r5: assert property (@(posedge clk) disable iff (bus_rst)
      (!rd_n && !sel_n && !per_sel) |-> !bus_rdy);

   p_write_no_wait_r2: assert property (@(posedge clk) disable iff (bus_rst)
      (!wr_n && !sel_n && rd_n) |-> bus_rdy);

   p_move_len_r9: assert property (@(posedge clk) disable iff (bus_rst)
      (st == MOVE_CODE) |-> (mv_run < DATA_W));
endmodule

bind ser_byte_bridge ser_byte_bridge_chk #(.DATA_W(DATA_W)) chk_i (
   .clk     (clk),
   .bus_rst (bus_rst),
   .rd_n    (rd_n),
   .wr_n    (wr_n),
   .sel_n   (sel_n),
   .bus_doe (bus_doe),
   .bus_rdy (bus_rdy),
   .per_sel (per_sel),
   .ser_oe  (ser_oe),
   .st      (st_q)
);

// File: tb/ser_byte_bridge_tb.sv
`timescale 1ns/1ps
module ser_byte_bridge_tb_top;
   localparam int CLK_PER = 10;
   localparam int W       = 8;

   logic         clk = 1'b0;
   logic         bus_rst = 1'b1;
   logic         rd_n = 1'b1, wr_n = 1'b1, sel_n = 1'b1;
   logic [W-1:0] bus_din = '0;
   logic [W-1:0] bus_dout;
   logic         bus_doe, bus_rdy, per_sel, sclk, ser_do, ser_oe;
   logic         ser_di = 1'b0;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   logic [W-1:0] pbyte = '0;
   logic [W-1:0] wcap  = '0;
   int           pcnt  = 0;
   int           wcount = 0;

   always #(CLK_PER/2) clk = ~clk;

   ser_byte_bridge #(.DATA_W(W)) dut_i (
      .clk(clk), .bus_rst(bus_rst), .rd_n(rd_n), .wr_n(wr_n), .sel_n(sel_n),
      .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_rdy(bus_rdy), .per_sel(per_sel), .sclk(sclk), .ser_do(ser_do),
      .ser_oe(ser_oe), .ser_di(ser_di)
   );

   // Peripheral model: sample outgoing bits, present incoming bits on sclk rise.
   always @(posedge sclk) begin
      if (ser_oe) begin
         wcap = {wcap[W-2:0], ser_do};
         wcount++;
      end else begin
         if (pcnt < W) ser_di = pbyte[W-1-pcnt];
         pcnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [W-1:0] b);
      @(negedge clk);
      wcount = 0;
      wr_n = 1'b0; sel_n = 1'b0; bus_din = b;
      #1 chk(bus_rdy == 1'b1, "R2 no wait on write", bus_rdy, 1);
      @(negedge clk);
      wr_n = 1'b1; sel_n = 1'b1;
      #1 chk(per_sel == 1'b1, "R8 select during write", per_sel, 1);
      chk(ser_oe == 1'b1, "R4 driver on during write", ser_oe, 1);
      repeat (12) @(negedge clk);
      #1 chk(wcap == b, "R3 serial byte out", wcap, b);
      chk(wcount == W, "R9 write clock count", wcount, W);
      chk(per_sel == 1'b0, "R8 select released", per_sel, 0);
      chk(ser_oe == 1'b0, "R4 driver off after write", ser_oe, 0);
   endtask

   task automatic do_read(input logic [W-1:0] b);
      int lowcnt;
      @(negedge clk);
      pbyte = b; pcnt = 0;
      rd_n = 1'b0; sel_n = 1'b0;
      lowcnt = 0;
      #1;
      while (!bus_rdy && lowcnt < 100) begin
         lowcnt++;
         chk(ser_oe == 1'b0, "R4 driver off during read", ser_oe, 0);
         @(negedge clk); #1;
      end
      chk(lowcnt == W + 1, "R5 stall length", lowcnt, W + 1);
      chk(bus_doe == 1'b1, "R6 output enabled", bus_doe, 1);
      chk(bus_dout == b, "R6 read byte", bus_dout, b);
      chk(pcnt == W, "R9 read clock count", pcnt, W);
      @(negedge clk);
      rd_n = 1'b1; sel_n = 1'b1;
      #1 chk(bus_doe == 1'b0, "R6 output off on release", bus_doe, 0);
      @(negedge clk);
      #1 chk(per_sel == 1'b0, "R8 idle after read", per_sel, 0);
   endtask

   initial begin
      #(CLK_PER * 150000);
      if (!ended) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(per_sel == 0 && bus_rdy == 1 && ser_oe == 0 && bus_doe == 0 && sclk == 0,
          "R1 reset outputs", {per_sel, bus_rdy, ser_oe, bus_doe}, 4'b0100);
      @(negedge clk); bus_rst = 1'b0;

      // R3/R5/R6 exhaustive sweep of byte values
      for (int i = 0; i < 256; i++) begin
         do_write(W'(i));
         do_read(W'(i ^ 8'h5A));
      end

      // R7 read arriving while a write shifts out
      begin
         int lowcnt;
         @(negedge clk);
         wcount = 0; pbyte = 8'hC3; pcnt = 0;
         wr_n = 1'b0; sel_n = 1'b0; bus_din = 8'h96;
         @(negedge clk);
         wr_n = 1'b1; sel_n = 1'b1;
         @(negedge clk);
         rd_n = 1'b0; sel_n = 1'b0;
         lowcnt = 0; #1;
         while (!bus_rdy && lowcnt < 100) begin
            lowcnt++; @(negedge clk); #1;
         end
         chk(lowcnt == 2 * W + 1, "R7 stall covers both", lowcnt, 2 * W + 1);
         chk(wcap == 8'h96 && wcount == W, "R7 write intact", wcap, 8'h96);
         chk(bus_dout == 8'hC3 && bus_doe, "R7 read intact", bus_dout, 8'hC3);
         @(negedge clk); rd_n = 1'b1; sel_n = 1'b1;
         repeat (2) @(negedge clk);
      end

      // R10 write strobe starting mid-transfer is ignored
      @(negedge clk);
      wcount = 0;
      wr_n = 1'b0; sel_n = 1'b0; bus_din = 8'hA5;
      @(negedge clk); wr_n = 1'b1; sel_n = 1'b1;
      repeat (2) @(negedge clk);
      wr_n = 1'b0; sel_n = 1'b0; bus_din = 8'h3C;
      @(negedge clk); wr_n = 1'b1; sel_n = 1'b1;
      repeat (20) @(negedge clk);
      #1 chk(wcap == 8'hA5, "R10 first byte kept", wcap, 8'hA5);
      chk(wcount == W, "R10 no extra clocks", wcount, W);
      chk(per_sel == 1'b0, "R10 back to idle", per_sel, 0);

      // R11 strobes without enable
      @(negedge clk);
      wcount = 0; pcnt = 0;
      wr_n = 1'b0; sel_n = 1'b1;
      @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
      #1 chk(bus_rdy == 1'b1, "R11 no stall without enable", bus_rdy, 1);
      repeat (12) @(negedge clk);
      rd_n = 1'b1;
      #1 chk(wcount == 0 && pcnt == 0, "R11 no clocks", wcount + pcnt, 0);
      chk(per_sel == 1'b0, "R11 select idle", per_sel, 0);

      // R1 reset in the middle of a read
      @(negedge clk);
      pbyte = 8'h11; pcnt = 0;
      rd_n = 1'b0; sel_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_rst = 1'b1;
      #1 chk(bus_rdy == 1'b1, "R1 ready forced in reset", bus_rdy, 1);
      @(negedge clk);
      rd_n = 1'b1; sel_n = 1'b1;
      #1 chk(per_sel == 0 && ser_oe == 0 && bus_doe == 0 && sclk == 0,
             "R1 mid-transfer reset", {per_sel, ser_oe, bus_doe, sclk}, 0);
      @(negedge clk); bus_rst = 1'b0;
      @(negedge clk);
      #1 chk(per_sel == 1'b0 && bus_rdy == 1'b1, "R1 idle after reset",
             {per_sel, bus_rdy}, 2'b01);

      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule